// File: doc/BRIEF.md
# Radix-4 Carry-Save Fractional Divider Core

This block divides a fractional dividend by a normalized fractional divisor. It produces one signed base-4 quotient digit per clock cycle. The partial remainder stays in redundant form: a sum vector and a carry vector, updated each step by a carry-save adder. No full-width subtraction takes place per step. Each digit comes from a 7-bit estimate, which is the sum of the leading bits of both vectors. That estimate is compared against constants chosen by three divisor bits.

The dividend is entered already scaled by one quarter, so the digit string `q1..qN` encodes `x / (4d)` as `sum q_j * 4^-j`. Once the last digit has been produced, a one-cycle completion pulse marks the point where two flags become valid. These flags give the sign of the final remainder and whether it is exactly zero, which a downstream convert-and-round stage needs. The digits leave the block as a stream, one per cycle while `busy` is high. The surrounding datapath assembles and rounds them. Exponent handling and operand unpacking belong to that surrounding logic.

Top module: `srt4_div`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `q_vld` are all low.
- R2: A `start` sampled high while idle captures `dividend` (X, any DW-bit value, read as X/2^DW) and `divisor` (D, with its top bit set, read as D/2^DW). From the next cycle, `busy` and `q_vld` stay high for exactly NITER consecutive cycles, and each of those cycles shows one digit.
- R3: `q_dig` is a 3-bit two's-complement digit. Whenever `q_vld` is high, its value lies in {-2,-1,0,1,2}.
- R4: After digit j, the partial remainder `T_j = 4*T_(j-1) - 4*q_j*D` (with `T_0 = X`) satisfies `3*|T_j| <= 8*D`. This is the convergence bound `|w| <= (2/3)d`.
- R5: `done` is high for exactly one cycle: the cycle right after the last digit. In that cycle `busy` and `q_vld` are low.
- R6: While `done` is high, and until the next accepted `start`, `rem_neg` equals `T_N < 0` and `rem_zero` equals `T_N == 0`.
- R7: A `start` that arrives while `busy` is high is ignored. The operation in flight keeps its captured operands and digit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | DW | Dividend fraction X |
| divisor | input | DW | Divisor fraction D, top bit must be 1 |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| q_vld | output | 1 | `q_dig` carries a quotient digit |
| q_dig | output | 3 | Signed quotient digit, two's complement |
| rem_neg | output | 1 | Final remainder is negative |
| rem_zero | output | 1 | Final remainder is exactly zero |

## Verification
A wrong digit choice, a bad multiple, or a lost carry-in pushes the remainder outside the convergence band. Because the bench re-derives the remainder from the emitted digits and checks the bound after every digit, such a fault usually shows within one or two digits. It does not wait for the final flags. Faults in the sign or zero detection only show in the completion cycle, where both flags are compared against the exact final remainder. Counter faults show as a digit run that is too short or too long, or as a missing or stretched `done` pulse.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } srt4_state_e;

    typedef logic signed [2:0] srt4_digit_t;

    localparam int EST_W    = 7;
    localparam int EST_FRAC = 4;
    localparam int IDX_W    = 3;

    // Lower bound (times 16) of the estimate interval that selects digit h,
    // indexed by the three divisor bits below the leading one.
    function automatic logic signed [EST_W-1:0] srt4_bound(input int h,
                                                           input logic [IDX_W-1:0] idx);
        int v;
        v = 0;
        case (h)
            2: case (idx)
                3'd0: v = 12; 3'd1: v = 14; 3'd2: v = 15; 3'd3: v = 16;
                3'd4: v = 18; 3'd5: v = 20; 3'd6: v = 20; default: v = 24;
            endcase
            1: case (idx)
                3'd0, 3'd1, 3'd2, 3'd3: v = 4;
                3'd4, 3'd5:             v = 6;
                default:                v = 8;
            endcase
            0: case (idx)
                3'd0:             v = -4;
                3'd1, 3'd2, 3'd3: v = -6;
                default:          v = -8;
            endcase
            default: case (idx)
                3'd0: v = -13; 3'd1: v = -15; 3'd2: v = -16; 3'd3: v = -18;
                3'd4: v = -20; 3'd5: v = -20; 3'd6: v = -22; default: v = -24;
            endcase
        endcase
        return EST_W'(v);
    endfunction

endpackage

// File: rtl/srt4_sel.sv
module srt4_sel
    import srt4_pkg::*;
(
    input  logic [EST_W-1:0] top_s,
    input  logic [EST_W-1:0] top_c,
    input  logic [IDX_W-1:0] idx,
    output srt4_digit_t      digit
);
    logic signed [EST_W-1:0] est;

    always_comb begin
        est = $signed(top_s + top_c);
        if (est >= srt4_bound(2, idx))
            digit = 3'sd2;
        else if (est >= srt4_bound(1, idx))
            digit = 3'sd1;
        else if (est >= srt4_bound(0, idx))
            digit = 3'sd0;
        else if (est >= srt4_bound(-1, idx))
            digit = -3'sd1;
        else
            digit = -3'sd2;
    end
endmodule

// File: rtl/srt4_csa.sv
module srt4_csa
    import srt4_pkg::*;
#(
    parameter int WW = 22
) (
    input  logic [WW-1:0] sh_s,
    input  logic [WW-1:0] sh_c,
    input  logic [WW-1:0] dvs,
    input  srt4_digit_t   digit,
    output logic [WW-1:0] nxt_s,
    output logic [WW-1:0] nxt_c
);
    logic [WW-1:0] mag;
    logic [WW-1:0] addend;
    logic          sub;
    logic [WW-1:0] maj;

    always_comb begin
        case (digit)
            3'sd2, -3'sd2: mag = {dvs[WW-2:0], 1'b0};
            3'sd1, -3'sd1: mag = dvs;
            default:       mag = '0;
        endcase
        sub    = (digit > 3'sd0);
        addend = sub ? ~mag : mag;
    end

    for (genvar b = 0; b < WW; b++) begin : g_fa
        assign nxt_s[b] = sh_s[b] ^ sh_c[b] ^ addend[b];
        assign maj[b]   = (sh_s[b] & sh_c[b]) | (sh_s[b] & addend[b]) | (sh_c[b] & addend[b]);
    end

    assign nxt_c = {maj[WW-2:0], sub};
endmodule

// File: rtl/srt4_szd.sv
module srt4_szd #(
    parameter int WW = 22
) (
    input  logic [WW-1:0] vs,
    input  logic [WW-1:0] vc,
    output logic [WW-1:0] whole,
    output logic          neg,
    output logic          zero
);
    always_comb begin
        whole = vs + vc;
        neg   = whole[WW-1];
        zero  = (whole == '0);
    end
endmodule

// File: rtl/srt4_div.sv
module srt4_div
    import srt4_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NITER = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic          q_vld,
    output logic [2:0]    q_dig,
    output logic          rem_neg,
    output logic          rem_zero
);
    localparam int FW = DW + 2;
    localparam int WW = FW + 4;
    localparam int CW = $clog2(NITER) + 1;

    srt4_state_e   state;
    logic [WW-1:0] ws, wc;
    logic [DW-1:0] dv;
    logic [CW-1:0] cnt;

    logic [WW-1:0] sh_s, sh_c, dvs_ext, nxt_s, nxt_c, w_all;
    srt4_digit_t   dig;

    assign sh_s    = {ws[WW-3:0], 2'b00};
    assign sh_c    = {wc[WW-3:0], 2'b00};
    assign dvs_ext = {4'b0000, dv, 2'b00};

    srt4_sel u_sel (
        .top_s (sh_s[WW-2 -: EST_W]),
        .top_c (sh_c[WW-2 -: EST_W]),
        .idx   (dv[DW-2 -: IDX_W]),
        .digit (dig)
    );

    srt4_csa #(.WW(WW)) u_csa (
        .sh_s  (sh_s),
        .sh_c  (sh_c),
        .dvs   (dvs_ext),
        .digit (dig),
        .nxt_s (nxt_s),
        .nxt_c (nxt_c)
    );

    srt4_szd #(.WW(WW)) u_szd (
        .vs    (ws),
        .vc    (wc),
        .whole (w_all),
        .neg   (rem_neg),
        .zero  (rem_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ws    <= '0;
            wc    <= '0;
            dv    <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ws    <= {{(WW-DW){1'b0}}, dividend};
                    wc    <= '0;
                    dv    <= divisor;
                    cnt   <= '0;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    ws  <= nxt_s;
                    wc  <= nxt_c;
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(NITER - 1))
                        state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state == ST_RUN);
    assign done  = (state == ST_FIN);
    assign q_vld = busy;
    assign q_dig = dig;

    // Magnitude bound of the remainder, checked while digits are produced.
    logic [WW-1:0] w_mag;
    logic [WW+1:0] bnd_l, bnd_r;
    always_comb begin
        w_mag = w_all[WW-1] ? (~w_all + 1'b1) : w_all;
        bnd_l = {2'b00, w_mag} + {1'b0, w_mag, 1'b0};
        bnd_r = {1'b0, dvs_ext, 1'b0};
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        q_vld |-> ($signed(q_dig) >= -3'sd2 && $signed(q_dig) <= 3'sd2)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (busy || done) |-> (bnd_l <= bnd_r)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R5
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(rem_neg) && $stable(rem_zero))); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(dv)); // R7
endmodule

// File: tb/srt4_div_bench.sv
module srt4_div_bench;
    localparam int DW = 16;
    localparam int N  = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] x = '0;
    logic [DW-1:0] d = 16'h8000;
    logic          busy, done, q_vld, rem_neg, rem_zero;
    logic [2:0]    q_dig;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    srt4_div #(.DW(DW), .NITER(N)) u_srt4_div (
        .clk(clk), .rst(rst), .start(start), .dividend(x), .divisor(d),
        .busy(busy), .done(done), .q_vld(q_vld), .q_dig(q_dig),
        .rem_neg(rem_neg), .rem_zero(rem_zero)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint labs(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic run_div(input logic [DW-1:0] xv, input logic [DW-1:0] dv, input bit inject);
        longint t;
        longint dd;
        int     qv;
        t  = longint'(xv);
        dd = longint'(dv);
        @(negedge clk);
        start = 1'b1; x = xv; d = dv;
        @(negedge clk);
        start = 1'b0;
        for (int j = 1; j <= N; j++) begin
            chk(q_vld && busy, "R2 digit valid", longint'(q_vld), 1);
            qv = int'($signed(q_dig));
            chk(qv >= -2 && qv <= 2, "R3 digit range", qv, 0);
            t = 4 * t - 4 * longint'(qv) * dd;
            chk(3 * labs(t) <= 8 * dd, "R4 remainder bound", 3 * labs(t), 8 * dd);
            if (inject && j == 3) begin
                start = 1'b1; x = 16'h1234; d = 16'hF00D;  // R7: must be ignored
            end
            if (inject && j == 4) start = 1'b0;
            @(negedge clk);
        end
        chk(done && !busy && !q_vld, "R5 done after last digit", {busy, done, q_vld}, 3'b010);
        chk(rem_neg == (t < 0), "R6 sign flag", rem_neg, longint'(t < 0));
        chk(rem_zero == (t == 0), "R6 zero flag", rem_zero, longint'(t == 0));
        @(negedge clk);
        chk(!done && !busy, "R5 done single cycle", {busy, done}, 0);
        chk(rem_neg == (t < 0) && rem_zero == (t == 0), "R6 flags held",
            {rem_neg, rem_zero}, {t < 0, t == 0});
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !q_vld, "R1 reset state", {busy, done, q_vld}, 0);

        run_div(16'h8000, 16'h8000, 1'b0);   // exact quarter, zero remainder
        run_div(16'hFFFF, 16'hFFFF, 1'b0);
        run_div(16'h0000, 16'hC000, 1'b0);   // zero dividend
        run_div(16'hFFFF, 16'h8000, 1'b0);   // largest quotient
        run_div(16'h0001, 16'hFFFF, 1'b0);   // smallest nonzero
        run_div(16'h8000, 16'h9999, 1'b0);
        run_div(16'h5555, 16'hAAAB, 1'b1);   // R7 start while busy

        for (int k = 0; k < 400; k++) begin
            run_div(16'($urandom), 16'h8000 | 16'($urandom), (k % 10) == 3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule